// File: doc/BRIEF.md
# Pulse Amplitude and Timing Extractor with Tower Sums

This block sits in the off-detector readout path. It takes one digitized sample per channel for every bunch crossing. It removes a per-channel baseline from each sample. Two five-tap linear FIR filters then run side by side. One filter estimates the pulse amplitude. The other estimates the amplitude multiplied by the pulse time offset. The amplitude estimates of a programmable group of channels are added in a fixed-depth adder tree, which gives a digital trigger tower sum.

All channels of one crossing travel together as one beat on a valid/ready stream, tagged with a crossing number. The result beat carries the per-channel amplitude, the gated time product, a time-valid flag for each channel, the tower sum and the same crossing tag. Back-pressure stalls the whole pipeline at once.

Stream rules:
- A beat transfers on any cycle where valid and ready are both high.
- The output beat stays unchanged while `out_valid` is high and `out_ready` is low.
- `in_ready` is low only in that same stalled case.

The latency is five clock cycles, well inside a forty-crossing budget. Coefficients, pedestals, the time threshold and the tower size are plain control pins.

Top module: `amp_time_tower`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and all filter history, coefficients and pedestals are zero.
- R2: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output holds its value and no input beat is taken. No beat is lost or duplicated across a stall.
- R3: With `out_ready` held high, the result of a beat accepted at clock edge k becomes valid just after edge k+4 and not earlier. `out_tag` then equals that beat's `in_tag`.
- R4: Each channel's filter input is its 12-bit unsigned sample minus its 12-bit unsigned pedestal, as a signed value. A pedestal is written when `ped_we` is high, to the channel `ped_ch`, with the value `ped_val`.
- R5: The amplitude filter computes acc = sum over k=0..4 of ca[k]*x[n-k], where x[n] is the newest accepted input. The output is acc shifted right arithmetically by 8. Coefficients are signed 16-bit. They are written when `coef_we` is high, with `coef_bank`=0 selecting the amplitude set and `coef_idx` giving k.
- R6: The time filter uses the same form with the coefficients of `coef_bank`=1. Its result, shifted right arithmetically by 8, is a signed 24-bit value per channel.
- R7: When a channel's (saturated) amplitude is greater than the signed value `amp_thr`, its `out_tvalid` bit is 1 and `out_time` carries the time result. Otherwise `out_tvalid` is 0 and `out_time` is 0.
- R8: The amplitude output is signed 16-bit and saturates to 32767 or -32768 instead of wrapping.
- R9: `out_sum` adds the amplitudes of channels 0..N-1. N is `tower_size` clamped to the range 8..32.
- R10: `out_sum` is signed 18-bit and saturates to 131071 or -131072.
- R11: The filter history shifts only when an input beat is accepted. Idle cycles and stalled cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per processing step |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_bank | input | 1 | 0 amplitude set, 1 time set |
| coef_idx | input | 3 | Tap index 0..4, 0 weights the newest sample |
| coef_val | input | 16 | Signed coefficient value |
| ped_we | input | 1 | Pedestal write strobe |
| ped_ch | input | 5 | Channel to write |
| ped_val | input | 12 | Pedestal value |
| amp_thr | input | 16 | Signed amplitude threshold for time reporting |
| tower_size | input | 6 | Channels in the tower, clamped to 8..32 |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_samples | input | 384 | 32 samples of 12 bits, channel c at bits c*12 |
| in_tag | input | 12 | Crossing number of the input beat |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer ready |
| out_amp | output | 512 | 32 signed amplitudes of 16 bits |
| out_time | output | 768 | 32 signed gated time products of 24 bits |
| out_tvalid | output | 32 | Per-channel time-valid flags |
| out_sum | output | 18 | Signed saturated tower sum |
| out_tag | output | 12 | Crossing number of the result |

## Verification
The hardest case to reach is a stall that meets the filter history. A result is held at the output while the next beat is already offered at the input, and the delayed taps must later see exactly the beats that were accepted. The stimulus gets there by holding `out_ready` low once the first result appears. The second beat is kept valid through the stall, then `out_ready` is released so that one edge both drains and accepts. Separately, taps that weight only older samples are combined with idle gaps between beats. The saturation corners are reached by driving the largest coefficient against full-scale positive and negative pedestal-corrected samples.

// File: rtl/att_pkg.sv
package att_pkg;
  localparam int TAPS = 5;
  localparam int LAT  = 5;
  typedef enum logic {BANK_AMP = 1'b0, BANK_TIME = 1'b1} coef_bank_e;
endpackage

// File: rtl/att_chan.sv
module att_chan
  import att_pkg::*;
#(
  parameter int SW   = 12,
  parameter int CW   = 16,
  parameter int AW   = 16,
  parameter int FRAC = 8,
  localparam int DW   = SW + 1,
  localparam int ACCW = DW + CW + $clog2(TAPS),
  localparam int TW   = ACCW - FRAC
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 shift,
  input  logic [SW-1:0]        sample,
  input  logic [SW-1:0]        ped,
  input  logic [TAPS*CW-1:0]   coef_a,
  input  logic [TAPS*CW-1:0]   coef_t,
  input  logic signed [AW-1:0] thr,
  output logic signed [AW-1:0] amp,
  output logic signed [TW-1:0] tim,
  output logic                 tval
);
  localparam logic signed [TW-1:0] AMAX = {{(TW-AW+1){1'b0}}, {(AW-1){1'b1}}};
  localparam logic signed [TW-1:0] AMIN = {{(TW-AW+1){1'b1}}, {(AW-1){1'b0}}};

  logic signed [DW-1:0]   hist [TAPS];
  logic signed [ACCW-1:0] sum_a, sum_t, acc_a, acc_t;
  logic signed [TW-1:0]   sc_a, sc_t;
  logic signed [AW-1:0]   amp_c;

  // stage 1: baseline removal into the tap history (moves on accepted beats only)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) hist[k] <= '0;
    end else if (shift) begin
      hist[0] <= $signed({1'b0, sample}) - $signed({1'b0, ped});
      for (int k = 1; k < TAPS; k++) hist[k] <= hist[k-1];
    end
  end

  // stage 2: paired multiply-accumulate
  always_comb begin
    sum_a = '0;
    sum_t = '0;
    for (int k = 0; k < TAPS; k++) begin
      sum_a = sum_a + ACCW'(hist[k]) * ACCW'($signed(coef_a[k*CW +: CW]));
      sum_t = sum_t + ACCW'(hist[k]) * ACCW'($signed(coef_t[k*CW +: CW]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_a <= '0;
      acc_t <= '0;
    end else if (en) begin
      acc_a <= sum_a;
      acc_t <= sum_t;
    end
  end

  // stage 3: scaling, clamping and threshold gate
  assign sc_a = acc_a[ACCW-1:FRAC];
  assign sc_t = acc_t[ACCW-1:FRAC];

  always_comb begin
    if (sc_a > AMAX)      amp_c = AMAX[AW-1:0];
    else if (sc_a < AMIN) amp_c = AMIN[AW-1:0];
    else                  amp_c = sc_a[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amp  <= '0;
      tim  <= '0;
      tval <= 1'b0;
    end else if (en) begin
      amp <= amp_c;
      if (amp_c > thr) begin
        tim  <= sc_t;
        tval <= 1'b1;
      end else begin
        tim  <= '0;
        tval <= 1'b0;
      end
    end
  end

  assert_hist_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(hist[0]));

  assert_time_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tval |-> (tim == '0));
endmodule

// File: rtl/att_tower.sv
module att_tower #(
  parameter int NCH = 32,
  parameter int AW  = 16,
  parameter int GRP = 8,
  parameter int OW  = 18,
  localparam int NG = NCH / GRP,
  localparam int PW = AW + $clog2(GRP),
  localparam int FW = PW + $clog2(NG),
  localparam int NW = $clog2(NCH + 1)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [NCH*AW-1:0]    amps,
  input  logic [NW-1:0]        size,
  output logic signed [OW-1:0] sum
);
  localparam logic signed [FW-1:0] SMAX = {{(FW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [FW-1:0] SMIN = {{(FW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  function automatic logic signed [PW-1:0] grp_sum(input logic [NCH*AW-1:0] v,
                                                   input int base, input int lim);
    logic signed [PW-1:0] s;
    s = '0;
    for (int i = 0; i < GRP; i++)
      if (base + i < lim) s = s + PW'($signed(v[(base+i)*AW +: AW]));
    return s;
  endfunction

  logic [NW-1:0]        n_eff;
  logic signed [PW-1:0] psum [NG];
  logic signed [PW-1:0] part [NG];
  logic signed [FW-1:0] fsum;
  logic signed [OW-1:0] sat_c;

  always_comb begin
    if (int'(size) < GRP)      n_eff = NW'(GRP);
    else if (int'(size) > NCH) n_eff = NW'(NCH);
    else                       n_eff = size;
  end

  // level 1: one partial sum per group of channels
  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign psum[g] = grp_sum(amps, g * GRP, int'(n_eff));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) part[g] <= '0;
    end else if (en) begin
      for (int g = 0; g < NG; g++) part[g] <= psum[g];
    end
  end

  // level 2: final add and clamp
  always_comb begin
    fsum = '0;
    for (int g = 0; g < NG; g++) fsum = fsum + FW'(part[g]);
    if (fsum > SMAX)      sat_c = SMAX[OW-1:0];
    else if (fsum < SMIN) sat_c = SMIN[OW-1:0];
    else                  sat_c = fsum[OW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sum <= '0;
    else if (en) sum <= sat_c;
  end

  assert_sum_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(sum));
endmodule

// File: rtl/amp_time_tower.sv
module amp_time_tower
  import att_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int SW   = 12,
  parameter int CW   = 16,
  parameter int AW   = 16,
  parameter int FRAC = 8,
  parameter int SUMW = 18,
  parameter int TAGW = 12,
  parameter int GRP  = 8,
  localparam int TW  = SW + 1 + CW + $clog2(TAPS) - FRAC,
  localparam int IW  = $clog2(TAPS),
  localparam int CHW = $clog2(NCH),
  localparam int NW  = $clog2(NCH + 1)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 coef_we,
  input  logic                 coef_bank,
  input  logic [IW-1:0]        coef_idx,
  input  logic [CW-1:0]        coef_val,
  input  logic                 ped_we,
  input  logic [CHW-1:0]       ped_ch,
  input  logic [SW-1:0]        ped_val,
  input  logic signed [AW-1:0] amp_thr,
  input  logic [NW-1:0]        tower_size,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NCH*SW-1:0]    in_samples,
  input  logic [TAGW-1:0]      in_tag,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NCH*AW-1:0]    out_amp,
  output logic [NCH*TW-1:0]    out_time,
  output logic [NCH-1:0]       out_tvalid,
  output logic [SUMW-1:0]      out_sum,
  output logic [TAGW-1:0]      out_tag
);
  logic               en, shift;
  logic [LAT-1:0]     vq;
  logic [TAGW-1:0]    tq [LAT];
  logic [TAPS*CW-1:0] ca_r, ct_r;
  logic [SW-1:0]      ped_r [NCH];
  logic [NCH*AW-1:0]  a3, a4, a5;
  logic [NCH*TW-1:0]  tm3, tm4, tm5;
  logic [NCH-1:0]     tv3, tv4, tv5;

  assign en       = !vq[LAT-1] || out_ready;
  assign in_ready = en;
  assign shift    = en && in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca_r <= '0;
      ct_r <= '0;
      for (int c = 0; c < NCH; c++) ped_r[c] <= '0;
    end else begin
      if (coef_we && int'(coef_idx) < TAPS) begin
        if (coef_bank_e'(coef_bank) == BANK_TIME) ct_r[int'(coef_idx)*CW +: CW] <= coef_val;
        else                                      ca_r[int'(coef_idx)*CW +: CW] <= coef_val;
      end
      if (ped_we) ped_r[ped_ch] <= ped_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vq <= '0;
      for (int i = 0; i < LAT; i++) tq[i] <= '0;
    end else if (en) begin
      vq    <= {vq[LAT-2:0], in_valid};
      tq[0] <= in_tag;
      for (int i = 1; i < LAT; i++) tq[i] <= tq[i-1];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    att_chan #(.SW(SW), .CW(CW), .AW(AW), .FRAC(FRAC)) i_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .shift  (shift),
      .sample (in_samples[c*SW +: SW]),
      .ped    (ped_r[c]),
      .coef_a (ca_r),
      .coef_t (ct_r),
      .thr    (amp_thr),
      .amp    (a3[c*AW +: AW]),
      .tim    (tm3[c*TW +: TW]),
      .tval   (tv3[c])
    );
  end

  // align per-channel results with the two-level tower tree
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a4 <= '0; a5 <= '0; tm4 <= '0; tm5 <= '0; tv4 <= '0; tv5 <= '0;
    end else if (en) begin
      a4 <= a3;  a5 <= a4;
      tm4 <= tm3; tm5 <= tm4;
      tv4 <= tv3; tv5 <= tv4;
    end
  end

  att_tower #(.NCH(NCH), .AW(AW), .GRP(GRP), .OW(SUMW)) i_tower (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .amps  (a3),
    .size  (tower_size),
    .sum   (out_sum)
  );

  assign out_valid  = vq[LAT-1];
  assign out_tag    = tq[LAT-1];
  assign out_amp    = a5;
  assign out_time   = tm5;
  assign out_tvalid = tv5;

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_amp)
                                   && $stable(out_time) && $stable(out_tvalid)));
endmodule

// File: tb/test_amp_time_tower.sv
`timescale 1ns/1ps
module test_amp_time_tower;
  localparam int NCH = 32;
  localparam int SW  = 12;
  localparam int AW  = 16;
  localparam int TW  = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coef_we = 1'b0, coef_bank = 1'b0;
  logic [2:0] coef_idx = '0;
  logic [15:0] coef_val = '0;
  logic ped_we = 1'b0;
  logic [4:0] ped_ch = '0;
  logic [11:0] ped_val = '0;
  logic signed [15:0] amp_thr = '0;
  logic [5:0] tower_size = 6'd32;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [NCH*SW-1:0] in_samples = '0;
  logic [11:0] in_tag = '0, out_tag;
  logic [NCH*AW-1:0] out_amp;
  logic [NCH*TW-1:0] out_time;
  logic [NCH-1:0] out_tvalid;
  logic [17:0] out_sum;

  int checks = 0, errors = 0;
  int ca[5], ct[5], ped[NCH], hist[NCH][5], smp[NCH];
  int thr = 0, tsize = 32;
  int e_amp[NCH], e_time[NCH], e_tv[NCH], e_sum, e_tag;

  always #2 clk = ~clk;

  amp_time_tower i_amp_time_tower (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_bank(coef_bank),
    .coef_idx(coef_idx), .coef_val(coef_val), .ped_we(ped_we), .ped_ch(ped_ch),
    .ped_val(ped_val), .amp_thr(amp_thr), .tower_size(tower_size),
    .in_valid(in_valid), .in_ready(in_ready), .in_samples(in_samples), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_amp(out_amp), .out_time(out_time),
    .out_tvalid(out_tvalid), .out_sum(out_sum), .out_tag(out_tag));

  task automatic chk(input int got, input int exp, input string req, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
    end
  endtask

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  task automatic model_shift(input int tag);
    int n, s;
    for (int c = 0; c < NCH; c++) begin
      int acc_a, acc_t;
      for (int k = 4; k > 0; k--) hist[c][k] = hist[c][k-1];
      hist[c][0] = smp[c] - ped[c];
      acc_a = 0; acc_t = 0;
      for (int k = 0; k < 5; k++) begin
        acc_a += ca[k] * hist[c][k];
        acc_t += ct[k] * hist[c][k];
      end
      e_amp[c] = clampi(acc_a >>> 8, -32768, 32767);
      e_tv[c]  = (e_amp[c] > thr) ? 1 : 0;
      e_time[c] = e_tv[c] ? (acc_t >>> 8) : 0;
    end
    n = clampi(tsize, 8, 32);
    s = 0;
    for (int c = 0; c < n; c++) s += e_amp[c];
    e_sum = clampi(s, -131072, 131071);
    e_tag = tag;
  endtask

  task automatic check_out(input string areq, input string sreq);
    chk(int'(out_valid), 1, "R3", "out_valid at latency");
    chk(int'(out_tag), e_tag, "R3", "out_tag");
    for (int c = 0; c < NCH; c++) begin
      chk(int'($signed(out_amp[c*AW +: AW])), e_amp[c], areq, $sformatf("amp ch%0d", c));
      chk(int'($signed(out_time[c*TW +: TW])), e_time[c], "R6", $sformatf("time ch%0d", c));
      chk(int'(out_tvalid[c]), e_tv[c], "R7", $sformatf("tvalid ch%0d", c));
    end
    chk(int'($signed(out_sum)), e_sum, sreq, "tower sum");
  endtask

  task automatic drive_beat(input int tag);
    for (int c = 0; c < NCH; c++) in_samples[c*SW +: SW] = SW'(smp[c]);
    in_tag = 12'(tag);
    in_valid = 1'b1;
  endtask

  task automatic push(input int tag, input string areq, input string sreq);
    model_shift(tag);
    @(negedge clk);
    chk(int'(in_ready), 1, "R2", "in_ready when idle");
    drive_beat(tag);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(int'(out_valid), 0, "R3", "no result before latency");
    @(posedge clk);
    @(negedge clk);
    check_out(areq, sreq);
  endtask

  task automatic wr_coef(input int bank, input int idx, input int val);
    @(negedge clk);
    coef_we = 1'b1; coef_bank = bank[0]; coef_idx = 3'(idx); coef_val = 16'(val);
    @(negedge clk);
    coef_we = 1'b0;
    if (bank == 0) ca[idx] = val; else ct[idx] = val;
  endtask

  task automatic set_coefs(input int a0, a1, a2, a3, a4, t0, t1, t2, t3, t4);
    wr_coef(0, 0, a0); wr_coef(0, 1, a1); wr_coef(0, 2, a2); wr_coef(0, 3, a3); wr_coef(0, 4, a4);
    wr_coef(1, 0, t0); wr_coef(1, 1, t1); wr_coef(1, 2, t2); wr_coef(1, 3, t3); wr_coef(1, 4, t4);
  endtask

  task automatic wr_ped(input int ch, input int val);
    @(negedge clk);
    ped_we = 1'b1; ped_ch = 5'(ch); ped_val = 12'(val);
    @(negedge clk);
    ped_we = 1'b0;
    ped[ch] = val;
  endtask

  task automatic set_ctrl(input int th, input int ts);
    @(negedge clk);
    amp_thr = 16'(th); tower_size = 6'(ts);
    thr = th; tsize = ts;
  endtask

  // R1: reset state
  task automatic t_reset();
    @(negedge clk);
    chk(int'(out_valid), 0, "R1", "out_valid after reset");
    chk(int'(in_ready), 1, "R1", "in_ready after reset");
    chk(int'(out_sum), 0, "R1", "out_sum after reset");
    for (int c = 0; c < NCH; c++) begin ped[c] = 0; for (int k = 0; k < 5; k++) hist[c][k] = 0; end
    for (int k = 0; k < 5; k++) begin ca[k] = 0; ct[k] = 0; end
    // coefficients zero after reset: a beat gives zero amplitude
    for (int c = 0; c < NCH; c++) smp[c] = 3000;
    push(1, "R1", "R1");
  endtask

  // R4, R5, R3: unit tap, per-channel pedestals
  task automatic t_identity();
    set_coefs(256, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    set_ctrl(32767, 32);
    for (int c = 0; c < NCH; c++) wr_ped(c, c * 10);
    for (int c = 0; c < NCH; c++) smp[c] = 1000 + c;
    push(2, "R4", "R9");
  endtask

  // R5, R6, R7: multi-tap pulse, threshold split across channels
  task automatic t_pulse();
    set_coefs(64, 128, 256, 128, 64, -300, -100, 0, 100, 300);
    set_ctrl(300, 32);
    for (int c = 0; c < NCH; c++) wr_ped(c, (c % 3 == 0) ? 2000 : 100);
    for (int n = 0; n < 4; n++) begin
      for (int c = 0; c < NCH; c++) smp[c] = 300 + ((c * 37 + n * 511) % 2000);
      push(10 + n, "R5", "R9");
    end
  endtask

  // R11: history ignores idle gaps, delayed tap sees the previous accepted beat
  task automatic t_bubble();
    set_coefs(0, 256, 0, 0, 0, 0, 0, 256, 0, 0);
    set_ctrl(-32768, 32);
    for (int c = 0; c < NCH; c++) smp[c] = 200 + 50 * c;
    push(20, "R11", "R9");
    repeat (12) @(posedge clk);
    for (int c = 0; c < NCH; c++) smp[c] = 4000 - 60 * c;
    push(21, "R11", "R9");
    repeat (7) @(posedge clk);
    for (int c = 0; c < NCH; c++) smp[c] = 5 * c;
    push(22, "R11", "R9");
  endtask

  // R8: amplitude clamps both ways
  task automatic t_amp_sat();
    set_coefs(32767, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    set_ctrl(0, 32);
    for (int c = 0; c < NCH; c++) begin
      wr_ped(c, (c % 2 == 0) ? 0 : 4095);
      smp[c] = (c % 2 == 0) ? 4095 : 0;
    end
    push(30, "R8", "R9");
  endtask

  // R9, R10: tower size selection, clamping of size and of the sum
  task automatic t_tower();
    int sizes[5] = '{8, 20, 32, 5, 40};
    set_coefs(256, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int c = 0; c < NCH; c++) wr_ped(c, 0);
    for (int c = 0; c < NCH; c++) smp[c] = c + 1;
    foreach (sizes[i]) begin
      set_ctrl(32767, sizes[i]);
      push(40 + i, "R9", "R9");
    end
    set_coefs(32767, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    set_ctrl(32767, 32);
    for (int c = 0; c < NCH; c++) smp[c] = 4095;
    push(50, "R8", "R10");
    for (int c = 0; c < NCH; c++) wr_ped(c, 4095);
    for (int c = 0; c < NCH; c++) smp[c] = 0;
    push(51, "R8", "R10");
  endtask

  // R2: back-pressure with the next beat waiting
  task automatic t_stall();
    int hold_sum, hold_tag;
    set_coefs(128, 128, 0, 0, 0, 0, 0, 0, 0, 0);
    set_ctrl(32767, 16);
    for (int c = 0; c < NCH; c++) wr_ped(c, 50);
    for (int c = 0; c < NCH; c++) smp[c] = 1500 + 20 * c;
    model_shift(60);
    @(negedge clk);
    out_ready = 1'b0;
    drive_beat(60);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_out("R2", "R2");
    hold_sum = int'($signed(out_sum));
    hold_tag = int'(out_tag);
    for (int c = 0; c < NCH; c++) smp[c] = 900 - 10 * c;
    drive_beat(61);
    chk(int'(in_ready), 0, "R2", "in_ready low while stalled");
    for (int i = 0; i < 5; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(int'(in_ready), 0, "R2", "in_ready stays low");
      chk(int'(out_valid), 1, "R2", "out_valid held");
      chk(int'(out_tag), hold_tag, "R2", "tag held");
      chk(int'($signed(out_sum)), hold_sum, "R2", "sum held");
    end
    out_ready = 1'b1;
    model_shift(61);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(int'(out_valid), 0, "R2", "held beat drained once");
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(int'(out_valid), 0, "R3", "no result before latency");
    @(posedge clk);
    @(negedge clk);
    check_out("R2", "R2");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_identity();
    t_pulse();
    t_bubble();
    t_amp_sat();
    t_tower();
    t_stall();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired got 0 exp 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule